// File: doc/BRIEF.md
# Instruction word class decoder with operand-word tracking

This block takes the 16-bit instruction words of a small 8-bit RISC microcontroller one at a time. For each word it names the instruction class and pulls out the operand fields: destination register, source register, 8-bit immediate, I/O address, bit index and signed relative offset. It also reports three things about the word. The first is whether a second address word follows it. The second is whether the instruction may move the program counter by anything other than a plain increment. The third is whether the encoding belongs to an unused or partly ignored part of the opcode space. Fields that a class does not use are driven to zero.

Words that belong to no instruction are handled by a two-state stream tracker. In state `SW_OPCODE` each accepted word is decoded as an instruction. When a two-word instruction is accepted, the tracker takes the transition `to_operand` into `SW_OPERAND`. The next accepted word is then reported only as an operand word, and the transition `to_opcode` returns the tracker to `SW_OPCODE`. Cycles with `in_valid` low take the transition `hold`, which leaves the state as it is. The result passes through an output stage that is a register by default (parameter `OUT_REG`) or a direct path. The parameter `PM_EXT_BITS` sets how many high address bits of an absolute jump or call count as valid. Its default of 0 accepts only the form with all high bits zero, which is enough for program memories up to 128K.

Class codes (`out_class`): NOP=0, REG_REG=1, CMP_SKIP=2, REG_IMM=3, LOAD_IMM=4, MEM_DISP=5, MEM_DIRECT=6, MEM_OTHER=7, ONE_REG=8, WORD_IMM=9, IO_BIT=10, IO_SKIP=11, IO_XFER=12, REL_JUMP=13, ABS_JUMP=14, INDIRECT=15, RETURN=16, BRANCH=17, REG_BIT=18, REG_SKIP=19, STATUS=20, CONTROL=21, UNUSED=22, OPERAND=23.

Top module: `rsc_opword_decoder`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first word is accepted, `out_valid` is 0 and the tracker is in `SW_OPCODE`.
- R2: With `OUT_REG`=1, the result for a word accepted at a clock edge appears at the next edge. `out_valid` repeats `in_valid` one cycle later.
- R3: `out_two_word` is 1 for words 1001 00xr rrrr 0000 (direct load/store, class MEM_DIRECT, rd = bits 8:4) and for 1001 010k kkkk 11xk (absolute jump/call, class ABS_JUMP). It is 0 for all other words.
- R4: The word accepted after a two-word instruction is reported as class OPERAND with `out_operand`=1 and `out_two_word`, `out_pc_change` and `out_unused` all 0, whatever its bits are. Idle cycles between the two words do not cancel this.
- R5: For ABS_JUMP, the 6-bit high address {bits 8:4, bit 0} must be below 2^`PM_EXT_BITS`, or `out_unused` is 1. With the default of 0, any non-zero high bit is flagged.
- R6: A word 1011 xxxx xxxx xxxx is IO_XFER with `out_io_addr` = {bits 10:9, bits 3:0} and `out_rd` = bits 8:4. Bit 11 picks write (1) or read (0).
- R7: Leading nibbles 0011, 0100, 0101, 0110 and 0111 give REG_IMM, and 1110 gives LOAD_IMM. Both have `out_imm` = {bits 11:8, bits 3:0} and `out_rd` = 16 + bits 7:4.
- R8: Leading nibbles 1100 and 1101 give REL_JUMP with `out_rel` = bits 11:0. A word 1111 0xxx xxxx xxxx gives BRANCH with `out_rel` = bits 9:3 sign-extended to 12 bits and `out_bit` = bits 2:0.
- R9: `out_pc_change` is 1 exactly for these classes: REL_JUMP, ABS_JUMP, INDIRECT, RETURN, BRANCH, IO_SKIP, REG_SKIP and CMP_SKIP (0001 00xx). CMP_SKIP has rd = bits 8:4.
- R10: 0x0000 is NOP with `out_unused`=0. Words 0x0001 to 0x00FF are class UNUSED with `out_unused`=1.
- R11: A word 1111 1xxx xxxx xxxx decodes by bit 10 as REG_SKIP (1) or REG_BIT (0), with `out_rd` = bits 8:4 and `out_bit` = bits 2:0. Bit 3 set raises `out_unused` and changes nothing else, so 0xFFFF is REG_SKIP on register 31, bit 7.
- R12: A word 1001 10xx xxxx xxxx is IO_SKIP when bit 8 is 1 and IO_BIT when bit 8 is 0. It has `out_io_addr` = bits 7:3 and `out_bit` = bits 2:0.
- R13: The following words raise `out_unused`. In the 1001 00xx memory group, class MEM_OTHER: load sub-codes (bits 3:0) 3, 8 and 11, and store sub-codes 3 to 8 and 11. In the 1001 010x group, all of these give class UNUSED: sub-code 4; sub-code 8 with bit 8 set and bits 7:4 in 2 to 7 or 11; sub-code 9 other than register field 0, 1, 16 or 17; and sub-code 11. Within that group, 0x9508 and 0x9518 are RETURN, 0x9409 and 0x9509 are INDIRECT, and 0x9588 and 0x95A8 are CONTROL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An instruction stream word is present |
| in_word | input | 16 | Instruction stream word |
| out_valid | output | 1 | The result fields below are valid |
| out_class | output | 5 | Instruction class code |
| out_rd | output | 5 | Destination register index |
| out_rr | output | 5 | Source register index |
| out_imm | output | 8 | Immediate or displacement |
| out_io_addr | output | 6 | I/O address |
| out_bit | output | 3 | Bit index |
| out_rel | output | 12 | Signed relative offset |
| out_two_word | output | 1 | An address word follows |
| out_pc_change | output | 1 | May change the program counter other than by incrementing |
| out_unused | output | 1 | Unused or ignored-bit encoding |
| out_operand | output | 1 | This word is the address word of the previous instruction |

## Verification
The hardest case to reach from the ports is an address word whose own bits look like another two-word instruction, arriving after idle cycles, with a third two-word opcode right behind it. A decoder that loses the pending state during the gap, or that decodes the operand as an opcode, would go out of step with the stream. Directed stimulus covers this case: a jump whose address word is 0x940C with idle gaps, then a direct load, then a store whose address word is 0x9000. A long random stream, weighted towards the two-word families and containing random idle cycles, is then compared every clock against a behavioural model. The model tracks the pending state with its own flag.

// File: rtl/rsc_opword_pkg.sv
package rsc_opword_pkg;

    localparam int WORD_W   = 16;
    localparam int REG_W    = 5;
    localparam int IMM_W    = 8;
    localparam int IO_W     = 6;
    localparam int BIT_W    = 3;
    localparam int REL_W    = 12;
    localparam int CLS_W    = 5;
    localparam int JMP_HI_W = 6;

    typedef enum logic [CLS_W-1:0] {
        CL_NOP        = 5'd0,
        CL_REG_REG    = 5'd1,
        CL_CMP_SKIP   = 5'd2,
        CL_REG_IMM    = 5'd3,
        CL_LOAD_IMM   = 5'd4,
        CL_MEM_DISP   = 5'd5,
        CL_MEM_DIRECT = 5'd6,
        CL_MEM_OTHER  = 5'd7,
        CL_ONE_REG    = 5'd8,
        CL_WORD_IMM   = 5'd9,
        CL_IO_BIT     = 5'd10,
        CL_IO_SKIP    = 5'd11,
        CL_IO_XFER    = 5'd12,
        CL_REL_JUMP   = 5'd13,
        CL_ABS_JUMP   = 5'd14,
        CL_INDIRECT   = 5'd15,
        CL_RETURN     = 5'd16,
        CL_BRANCH     = 5'd17,
        CL_REG_BIT    = 5'd18,
        CL_REG_SKIP   = 5'd19,
        CL_STATUS     = 5'd20,
        CL_CONTROL    = 5'd21,
        CL_UNUSED     = 5'd22,
        CL_OPERAND    = 5'd23
    } iclass_e;

    typedef struct packed {
        iclass_e            cls;
        logic [REG_W-1:0]   rd;
        logic [REG_W-1:0]   rr;
        logic [IMM_W-1:0]   imm;
        logic [IO_W-1:0]    io;
        logic [BIT_W-1:0]   bitn;
        logic [REL_W-1:0]   rel;
        logic               two_word;
        logic               pc_change;
        logic               unused;
        logic               operand;
    } dec_t;

    typedef enum logic {
        SW_OPCODE  = 1'b0,
        SW_OPERAND = 1'b1
    } sw_state_e;

endpackage

// File: rtl/rsc_opword_classify.sv
module rsc_opword_classify
    import rsc_opword_pkg::*;
#(
    parameter int PM_EXT_BITS = 0
) (
    input  logic [WORD_W-1:0] word_i,
    output dec_t              dec_o
);

    localparam logic [JMP_HI_W-1:0] HI_OK_MASK = JMP_HI_W'((1 << PM_EXT_BITS) - 1);

    logic [3:0]          top_nib;
    logic [3:0]          sub_nib;
    logic [JMP_HI_W-1:0] jmp_hi;
    dec_t                d;

    assign top_nib = word_i[15:12];
    assign sub_nib = word_i[3:0];
    assign jmp_hi  = {word_i[8:4], word_i[0]};

    // memory group 1001 00xx: unused sub-codes differ for load and store
    function automatic logic mem_sub_unused(input logic is_store, input logic [3:0] s);
        if (is_store)
            return (s >= 4'd3 && s <= 4'd8) || s == 4'd11;
        else
            return s == 4'd3 || s == 4'd8 || s == 4'd11;
    endfunction

    always_comb begin
        d     = '0;
        d.cls = CL_UNUSED;
        unique case (top_nib)
            4'h0: begin
                if (word_i == '0) begin
                    d.cls = CL_NOP;
                end else if (word_i[11:8] == 4'h0) begin
                    d.cls    = CL_UNUSED;
                    d.unused = 1'b1;
                end else if (word_i[11:8] == 4'h1) begin
                    d.cls = CL_REG_REG;
                    d.rd  = {word_i[7:4], 1'b0};
                    d.rr  = {word_i[3:0], 1'b0};
                end else if (word_i[11:8] == 4'h2) begin
                    d.cls = CL_REG_REG;
                    d.rd  = {1'b1, word_i[7:4]};
                    d.rr  = {1'b1, word_i[3:0]};
                end else if (word_i[11:8] == 4'h3) begin
                    d.cls = CL_REG_REG;
                    d.rd  = {2'b10, word_i[6:4]};
                    d.rr  = {2'b10, word_i[2:0]};
                end else begin
                    d.cls = CL_REG_REG;
                    d.rd  = word_i[8:4];
                    d.rr  = {word_i[9], word_i[3:0]};
                end
            end
            4'h1, 4'h2: begin
                d.rd = word_i[8:4];
                d.rr = {word_i[9], word_i[3:0]};
                if (word_i[15:10] == 6'b000100) begin
                    d.cls       = CL_CMP_SKIP;
                    d.pc_change = 1'b1;
                end else begin
                    d.cls = CL_REG_REG;
                end
            end
            4'h3, 4'h4, 4'h5, 4'h6, 4'h7, 4'hE: begin
                d.cls = (top_nib == 4'hE) ? CL_LOAD_IMM : CL_REG_IMM;
                d.rd  = {1'b1, word_i[7:4]};
                d.imm = {word_i[11:8], word_i[3:0]};
            end
            4'h8, 4'hA: begin
                d.cls = CL_MEM_DISP;
                d.rd  = word_i[8:4];
                d.imm = {2'b00, word_i[13], word_i[11:10], word_i[2:0]};
            end
            4'h9: begin
                if (word_i[11:10] == 2'b00) begin
                    d.rd = word_i[8:4];
                    if (sub_nib == 4'h0) begin
                        d.cls      = CL_MEM_DIRECT;
                        d.two_word = 1'b1;
                    end else begin
                        d.cls    = CL_MEM_OTHER;
                        d.unused = mem_sub_unused(word_i[9], sub_nib);
                    end
                end else if (word_i[11:9] == 3'b010) begin
                    if (sub_nib <= 4'h7 || sub_nib == 4'hA) begin
                        if (sub_nib == 4'h4) begin
                            d.unused = 1'b1;
                        end else begin
                            d.cls = CL_ONE_REG;
                            d.rd  = word_i[8:4];
                        end
                    end else if (sub_nib == 4'h8) begin
                        if (!word_i[8]) begin
                            d.cls  = CL_STATUS;
                            d.bitn = word_i[6:4];
                        end else begin
                            unique case (word_i[7:4])
                                4'h0, 4'h1: begin
                                    d.cls       = CL_RETURN;
                                    d.pc_change = 1'b1;
                                end
                                4'h8, 4'h9, 4'hA, 4'hC, 4'hD, 4'hE, 4'hF:
                                    d.cls = CL_CONTROL;
                                default:
                                    d.unused = 1'b1;
                            endcase
                        end
                    end else if (sub_nib == 4'h9) begin
                        if (word_i[7:5] == 3'b000 && (word_i[8:4] & 5'b01110) == 5'd0) begin
                            d.cls       = CL_INDIRECT;
                            d.pc_change = 1'b1;
                        end else begin
                            d.unused = 1'b1;
                        end
                    end else if (sub_nib == 4'hB) begin
                        d.unused = 1'b1;
                    end else begin
                        d.cls       = CL_ABS_JUMP;
                        d.two_word  = 1'b1;
                        d.pc_change = 1'b1;
                        d.unused    = |(jmp_hi & ~HI_OK_MASK);
                    end
                end else if (word_i[11:9] == 3'b011) begin
                    d.cls = CL_WORD_IMM;
                    d.rd  = {2'b11, word_i[5:4], 1'b0};
                    d.imm = {2'b00, word_i[7:6], word_i[3:0]};
                end else if (word_i[11:10] == 2'b10) begin
                    d.cls       = word_i[8] ? CL_IO_SKIP : CL_IO_BIT;
                    d.pc_change = word_i[8];
                    d.io        = {1'b0, word_i[7:3]};
                    d.bitn      = word_i[2:0];
                end else begin
                    d.cls = CL_REG_REG;
                    d.rd  = word_i[8:4];
                    d.rr  = {word_i[9], word_i[3:0]};
                end
            end
            4'hB: begin
                d.cls = CL_IO_XFER;
                d.rd  = word_i[8:4];
                d.io  = {word_i[10:9], word_i[3:0]};
            end
            4'hC, 4'hD: begin
                d.cls       = CL_REL_JUMP;
                d.rel       = word_i[11:0];
                d.pc_change = 1'b1;
            end
            4'hF: begin
                if (!word_i[11]) begin
                    d.cls       = CL_BRANCH;
                    d.rel       = {{(REL_W-7){word_i[9]}}, word_i[9:3]};
                    d.bitn      = word_i[2:0];
                    d.pc_change = 1'b1;
                end else begin
                    d.cls       = word_i[10] ? CL_REG_SKIP : CL_REG_BIT;
                    d.pc_change = word_i[10];
                    d.rd        = word_i[8:4];
                    d.bitn      = word_i[2:0];
                    d.unused    = word_i[3];
                end
            end
            default: d.cls = CL_UNUSED;
        endcase
    end

    assign dec_o = d;

    always_comb begin
        if (!$isunknown(word_i)) begin
            a_r3_two_word_family: assert (!d.two_word || d.cls == CL_MEM_DIRECT || d.cls == CL_ABS_JUMP)
                else $error("two-word flag outside the direct and absolute families");
            a_r9_pc_only_flow: assert (!d.pc_change || d.cls inside {CL_REL_JUMP, CL_ABS_JUMP, CL_INDIRECT,
                    CL_RETURN, CL_BRANCH, CL_IO_SKIP, CL_REG_SKIP, CL_CMP_SKIP})
                else $error("pc change on a non-flow class");
            a_r10_low_page_unused: assert (!(word_i[15:8] == 8'h00 && word_i != '0) || d.unused)
                else $error("low page word not flagged");
            a_r11_bit3_flag: assert (word_i[15:11] != 5'b11111 || d.unused == word_i[3])
                else $error("bit-group unused flag does not follow bit 3");
        end
    end

endmodule

// File: rtl/rsc_opword_tracker.sv
module rsc_opword_tracker
    import rsc_opword_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic two_word_i,
    output logic operand_o
);

    sw_state_e state_q;
    sw_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SW_OPCODE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SW_OPCODE:  if (in_valid && two_word_i) state_d = SW_OPERAND;   // to_operand
            SW_OPERAND: if (in_valid)               state_d = SW_OPCODE;    // to_opcode
            default:    state_d = SW_OPCODE;
        endcase
    end

    always_comb begin
        operand_o = (state_q == SW_OPERAND);
    end

    a_r4_enter_operand: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && state_q == SW_OPCODE && two_word_i) |=> state_q == SW_OPERAND)
        else $error("two-word opcode did not arm operand state");

    a_r4_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(state_q))
        else $error("state moved on an idle cycle");

    a_r4_operand_once: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && state_q == SW_OPERAND) |=> state_q == SW_OPCODE)
        else $error("operand state held past its word");

endmodule

// File: rtl/rsc_opword_outstage.sv
module rsc_opword_outstage
    import rsc_opword_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic valid_i,
    input  dec_t dec_i,
    output logic valid_o,
    output dec_t dec_o
);

    generate
        if (OUT_REG) begin : g_reg
            logic valid_q;
            dec_t dec_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    valid_q <= 1'b0;
                    dec_q   <= '0;
                end else begin
                    valid_q <= valid_i;
                    dec_q   <= dec_i;
                end
            end
            assign valid_o = valid_q;
            assign dec_o   = dec_q;

            a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
                valid_i |=> valid_o)
                else $error("accepted word produced no result");
            a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
                !valid_i |=> !valid_o)
                else $error("result without an accepted word");
        end else begin : g_pass
            assign valid_o = valid_i;
            assign dec_o   = dec_i;
        end
    endgenerate

endmodule

// File: rtl/rsc_opword_decoder.sv
module rsc_opword_decoder
    import rsc_opword_pkg::*;
#(
    parameter bit OUT_REG     = 1'b1,
    parameter int PM_EXT_BITS = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    output logic              out_valid,
    output logic [CLS_W-1:0]  out_class,
    output logic [REG_W-1:0]  out_rd,
    output logic [REG_W-1:0]  out_rr,
    output logic [IMM_W-1:0]  out_imm,
    output logic [IO_W-1:0]   out_io_addr,
    output logic [BIT_W-1:0]  out_bit,
    output logic [REL_W-1:0]  out_rel,
    output logic              out_two_word,
    output logic              out_pc_change,
    output logic              out_unused,
    output logic              out_operand
);

    dec_t raw_dec;
    dec_t merged;
    dec_t res;
    logic operand_q;

    rsc_opword_classify #(.PM_EXT_BITS(PM_EXT_BITS)) u_classify (
        .word_i (in_word),
        .dec_o  (raw_dec)
    );

    rsc_opword_tracker u_tracker (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .two_word_i (raw_dec.two_word),
        .operand_o  (operand_q)
    );

    always_comb begin
        merged = raw_dec;
        if (operand_q) begin
            merged         = '0;
            merged.cls     = CL_OPERAND;
            merged.operand = 1'b1;
        end
    end

    rsc_opword_outstage #(.OUT_REG(OUT_REG)) u_outstage (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (in_valid),
        .dec_i   (merged),
        .valid_o (out_valid),
        .dec_o   (res)
    );

    assign out_class     = res.cls;
    assign out_rd        = res.rd;
    assign out_rr        = res.rr;
    assign out_imm       = res.imm;
    assign out_io_addr   = res.io;
    assign out_bit       = res.bitn;
    assign out_rel       = res.rel;
    assign out_two_word  = res.two_word;
    assign out_pc_change = res.pc_change;
    assign out_unused    = res.unused;
    assign out_operand   = res.operand;

endmodule

// File: tb/rsc_opword_decoder_bench.sv
module rsc_opword_decoder_bench;
    import rsc_opword_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_word = '0;
    logic        out_valid;
    logic [4:0]  out_class, out_rd, out_rr;
    logic [7:0]  out_imm;
    logic [5:0]  out_io_addr;
    logic [2:0]  out_bit;
    logic [11:0] out_rel;
    logic        out_two_word, out_pc_change, out_unused, out_operand;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    rsc_opword_decoder u_rsc_opword_decoder (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
        .out_valid(out_valid), .out_class(out_class), .out_rd(out_rd), .out_rr(out_rr),
        .out_imm(out_imm), .out_io_addr(out_io_addr), .out_bit(out_bit), .out_rel(out_rel),
        .out_two_word(out_two_word), .out_pc_change(out_pc_change),
        .out_unused(out_unused), .out_operand(out_operand)
    );

    typedef struct {
        int cls; int rd; int imm; int io; int bitn; int rel;
        bit two; bit pc; bit unu; bit opd; bit skip_rd;
    } exp_t;

    // behavioural reference, written from the requirement list
    function automatic exp_t ref_dec(input logic [15:0] w);
        exp_t e;
        int n;
        e = '{cls: 22, rd: 0, imm: 0, io: 0, bitn: 0, rel: 0,
              two: 0, pc: 0, unu: 0, opd: 0, skip_rd: 0};
        n = int'(w[3:0]);
        if (w == 16'h0000) e.cls = 0;
        else if (w[15:8] == 8'h00) e.unu = 1;
        else if (w[15:12] inside {4'h3, 4'h4, 4'h5, 4'h6, 4'h7, 4'hE}) begin
            e.cls = (w[15:12] == 4'hE) ? 4 : 3;
            e.rd  = 16 + int'(w[7:4]);
            e.imm = int'({w[11:8], w[3:0]});
        end else if (w[15:10] == 6'b000100) begin
            e.cls = 2; e.pc = 1; e.rd = int'(w[8:4]);
        end else if (w[15:14] == 2'b00) begin
            e.cls = 1; e.rd = int'(w[8:4]); e.skip_rd = (w[15:10] == 6'd0);
        end else if (w[15:14] == 2'b10 && w[12] == 1'b0) begin
            e.cls = 5; e.skip_rd = 1;
        end else if (w[15:10] == 6'b100100) begin
            e.rd = int'(w[8:4]);
            if (n == 0) begin e.cls = 6; e.two = 1; end
            else begin
                e.cls = 7;
                e.unu = w[9] ? ((n >= 3 && n <= 8) || n == 11) : (n == 3 || n == 8 || n == 11);
            end
        end else if (w[15:9] == 7'b1001010) begin
            if (n >= 12) begin
                e.cls = 14; e.two = 1; e.pc = 1;
                e.unu = ({w[8:4], w[0]} != 6'd0);
            end else if (n == 4 || n == 11) e.unu = 1;
            else if (n <= 7 || n == 10) begin e.cls = 8; e.rd = int'(w[8:4]); end
            else if (n == 9) begin
                if (w[8:4] inside {5'd0, 5'd1, 5'd16, 5'd17}) begin e.cls = 15; e.pc = 1; end
                else e.unu = 1;
            end else begin
                if (!w[8]) begin e.cls = 20; e.bitn = int'(w[6:4]); end
                else if (w[7:4] <= 4'd1) begin e.cls = 16; e.pc = 1; end
                else if (w[7:4] inside {4'h8, 4'h9, 4'hA, 4'hC, 4'hD, 4'hE, 4'hF}) e.cls = 21;
                else e.unu = 1;
            end
        end else if (w[15:9] == 7'b1001011) begin
            e.cls = 9; e.skip_rd = 1;
        end else if (w[15:10] == 6'b100110) begin
            e.cls = w[8] ? 11 : 10; e.pc = w[8];
            e.io = int'(w[7:3]); e.bitn = int'(w[2:0]);
        end else if (w[15:10] == 6'b100111) begin
            e.cls = 1; e.rd = int'(w[8:4]);
        end else if (w[15:12] == 4'hB) begin
            e.cls = 12; e.rd = int'(w[8:4]); e.io = int'({w[10:9], w[3:0]});
        end else if (w[15:13] == 3'b110) begin
            e.cls = 13; e.pc = 1; e.rel = int'(w[11:0]);
        end else if (w[15:11] == 5'b11110) begin
            e.cls = 17; e.pc = 1; e.bitn = int'(w[2:0]);
            e.rel = int'(w[9:3]) - (w[9] ? 128 : 0);
            e.rel = e.rel & 12'hFFF;
        end else begin
            e.cls = w[10] ? 19 : 18; e.pc = w[10];
            e.rd = int'(w[8:4]); e.bitn = int'(w[2:0]); e.unu = w[3];
        end
        return e;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d (time %0t)", tag, what, act, expv, $time);
        end
    endtask

    bit   pend_v   = 0;
    exp_t pend;
    bit   model_op = 0;

    task automatic compare();
        chk(out_valid == pend_v, "R2", "out_valid", int'(out_valid), int'(pend_v));
        if (pend_v && out_valid) begin
            chk(int'(out_class) == pend.cls, pend.opd ? "R4" : "R13", "class", int'(out_class), pend.cls);
            chk(out_operand == pend.opd, "R4", "operand", int'(out_operand), int'(pend.opd));
            chk(out_two_word == pend.two, "R3", "two_word", int'(out_two_word), int'(pend.two));
            chk(out_pc_change == pend.pc, "R9", "pc_change", int'(out_pc_change), int'(pend.pc));
            chk(out_unused == pend.unu, "R13", "unused", int'(out_unused), int'(pend.unu));
            if (pend.cls inside {1, 2, 3, 4, 6, 8, 12, 18, 19} && !pend.skip_rd)
                chk(int'(out_rd) == pend.rd, "R7", "rd", int'(out_rd), pend.rd);
            if (pend.cls inside {3, 4})
                chk(int'(out_imm) == pend.imm, "R7", "imm", int'(out_imm), pend.imm);
            if (pend.cls inside {10, 11, 12})
                chk(int'(out_io_addr) == pend.io, "R6", "io_addr", int'(out_io_addr), pend.io);
            if (pend.cls inside {10, 11, 17, 18, 19, 20})
                chk(int'(out_bit) == pend.bitn, "R12", "bit", int'(out_bit), pend.bitn);
            if (pend.cls inside {13, 17})
                chk(int'(out_rel) == pend.rel, "R8", "rel", int'(out_rel), pend.rel);
        end
    endtask

    // one clock: check the previous result, then present the next word
    task automatic step(input bit v, input logic [15:0] w);
        @(negedge clk);
        compare();
        in_valid = v;
        in_word  = w;
        pend_v   = v;
        if (v) begin
            if (model_op) begin
                pend = '{cls: 23, rd: 0, imm: 0, io: 0, bitn: 0, rel: 0,
                         two: 0, pc: 0, unu: 0, opd: 1, skip_rd: 0};
                model_op = 0;
            end else begin
                pend = ref_dec(w);
                model_op = pend.two;
            end
        end
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog expired (all requirements)");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
        // R10: no-op and unused low page
        step(1, 16'h0000); step(1, 16'h0001); step(1, 16'h00FF);
        // R7: immediates
        step(1, 16'hE5A3); step(1, 16'h3123); step(1, 16'h7FFF); step(1, 16'h4010);
        // R6: port transfers
        step(1, 16'hB012); step(1, 16'hBFFF);
        // R8: relative jumps and branches
        step(1, 16'hC7FF); step(1, 16'hD800); step(1, 16'hF3FF); step(1, 16'hF408);
        // R11: bit group including ignored bit 3
        step(1, 16'hFFFF); step(1, 16'hFF07); step(1, 16'hF808); step(1, 16'hFA05);
        // R12: low I/O bit operations
        step(1, 16'h985B); step(1, 16'h9BFF); step(1, 16'h9A01); step(1, 16'h9900);
        // R9 and R13: flow singletons and unused family members
        step(1, 16'h9508); step(1, 16'h9518); step(1, 16'h9409); step(1, 16'h9509);
        step(1, 16'h9588); step(1, 16'h95A8); step(1, 16'h9428); step(1, 16'h95B8);
        step(1, 16'h9524); step(1, 16'h94FB); step(1, 16'h9003); step(1, 16'h9205);
        step(1, 16'h1234); step(1, 16'h9429);
        // R3, R4, R5: two-word forms, operands that look like opcodes, idle gaps
        step(1, 16'h940C); step(0, 16'h0000); step(0, 16'hFFFF); step(1, 16'h940C);
        step(1, 16'h9010); step(1, 16'h1234);
        step(1, 16'h93F0); step(1, 16'h9000); step(1, 16'h0001);
        step(1, 16'h940D); step(1, 16'h0000);
        step(1, 16'h95FF); step(0, 16'h0000); step(1, 16'h940E);
        step(1, 16'h9508);
        // random stream weighted toward two-word families
        for (int i = 0; i < 4000; i++) begin
            logic [15:0] w;
            int pick;
            pick = int'($urandom % 6);
            w = 16'($urandom);
            if (pick == 0) w = {7'b1001010, w[8:4], 2'b11, w[0]};
            else if (pick == 1) w = {6'b100100, w[9:4], 4'h0};
            step(($urandom % 4) != 0, w);
        end
        step(0, 16'h0000);
        step(0, 16'h0000);
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule